// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block is a 32-pin general purpose I/O port controlled through a small memory-mapped register bus. It stores an output level and a drive direction for every pin, drives those values straight to the pad ring, and returns the pad levels after a two-flop synchronizer. A fixed version word can also be read.

Each 32-bit control register is split into two 16-bit halves at adjacent word addresses. The low half holds pins 0 to 15 and the high half, four bytes above it, holds pins 16 to 31. In every write, the upper 16 bits of the bus word are a per-bit write enable for the lower 16 bits. Software can therefore set or clear any group of pins in one bus write, with no read-modify-write and no lock.

A bus access is valid for one cycle. Read data is registered and appears on the cycle after the request.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted, and right after it is released, every output-level bit and every direction bit is 0, so all pins are inputs. The read data is 0.
- R2: A write to a half register changes stored bit i (i = 0..15) to write-data bit i only when write-data bit i+16 is 1. Every other stored bit keeps its value, and a write whose bits [31:16] are all 0 changes nothing.
- R3: The low half of a register (base offset) holds pins 0..15 and the high half (base + 0x4) holds pins 16..31. A write to one half leaves the other half unchanged.
- R4: The direction register is at byte offsets 0x08 (low half) and 0x0C (high half). Direction bit n appears on pad_oe[n], where 1 means output and 0 means input.
- R5: The output-level register is at byte offsets 0x00 (low half) and 0x04 (high half). Stored bit n appears on pad_out[n] on the cycle after the write.
- R6: A read of a half register returns its 16 stored bits in rdata[15:0] and 0 in rdata[31:16]. The value appears on the cycle after the read request.
- R7: A read of byte offset 0x70 returns pad_in with pin n at bit n, taken through a two-flop synchronizer. A pad change applied before clock edge A is returned by a read request sampled at the second edge after A, not earlier.
- R8: A read of byte offset 0x78 returns 0x0101157C. Writes to 0x70 and 0x78 change no state.
- R9: A read of any other offset, unaligned ones included, returns 0. A write to such an offset changes no register.
- R10: A write presented while bus_valid is 0 has no effect on pad_out or pad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write word: [31:16] bit enables, [15:0] data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | PIN_COUNT | Asynchronous pad levels |
| pad_out | output | PIN_COUNT | Output level to pads |
| pad_oe | output | PIN_COUNT | Output enable to pads, 1 = drive |

## Verification
The hardest case to reach from the ports is the exact synchronizer latency. The read data is itself registered, so a pad change and a read request interact across three edges. The stimulus changes pad_in on the same half-cycle as a read request and then issues two more reads back to back. It expects the old level twice and then the new one. Masked writes use enable patterns that clear some bits, keep others and enable none, and each pattern is followed by reads of both halves.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

   // byte offsets of the register windows
   localparam int unsigned OFS_DOUT    = 'h00;
   localparam int unsigned OFS_DIR     = 'h08;
   localparam int unsigned OFS_EXT     = 'h70;
   localparam int unsigned OFS_VER     = 'h78;
   localparam int unsigned OFS_HI_STEP = 'h04;

   // number of read/write control registers (level, direction)
   localparam int unsigned NUM_CTRL = 2;
   localparam int unsigned NUM_HALF = 2;

   typedef enum logic [2:0] {
      RGN_NONE    = 3'd0,
      RGN_DOUT_LO = 3'd1,
      RGN_DOUT_HI = 3'd2,
      RGN_DIR_LO  = 3'd3,
      RGN_DIR_HI  = 3'd4,
      RGN_EXT     = 3'd5,
      RGN_VER     = 3'd6
   } region_e;

   // region owned by control register r, half h
   function automatic region_e half_region(int unsigned r, int unsigned h);
      region_e res;
      if (r == 0) res = (h == 0) ? RGN_DOUT_LO : RGN_DOUT_HI;
      else        res = (h == 0) ? RGN_DIR_LO  : RGN_DIR_HI;
      return res;
   endfunction

endpackage

// File: rtl/gpio_mask_decode.sv
module gpio_mask_decode
   import gpio_mask_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   localparam logic [ADDR_W-1:0] A_DOUT_LO = ADDR_W'(OFS_DOUT);
   localparam logic [ADDR_W-1:0] A_DOUT_HI = ADDR_W'(OFS_DOUT + OFS_HI_STEP);
   localparam logic [ADDR_W-1:0] A_DIR_LO  = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_DIR_HI  = ADDR_W'(OFS_DIR + OFS_HI_STEP);
   localparam logic [ADDR_W-1:0] A_EXT     = ADDR_W'(OFS_EXT);
   localparam logic [ADDR_W-1:0] A_VER     = ADDR_W'(OFS_VER);

   always_comb begin
      region = RGN_NONE;
      if      (addr == A_DOUT_LO) region = RGN_DOUT_LO;
      else if (addr == A_DOUT_HI) region = RGN_DOUT_HI;
      else if (addr == A_DIR_LO)  region = RGN_DIR_LO;
      else if (addr == A_DIR_HI)  region = RGN_DIR_HI;
      else if (addr == A_EXT)     region = RGN_EXT;
      else if (addr == A_VER)     region = RGN_VER;
   end

endmodule

// File: rtl/gpio_mask_half_reg.sv
module gpio_mask_half_reg #(
   parameter int unsigned HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2*HALF_W-1:0]   wdata,
   output logic [HALF_W-1:0]     q
);

   // each bit owns its enable from the upper half of the word
   for (genvar b = 0; b < HALF_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[b] <= 1'b0;
         else if (wr_en && wdata[HALF_W+b])
            q[b] <= wdata[b];
      end
   end

endmodule

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_mask_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int unsigned    HALF_W      = 16,
   parameter int unsigned    ADDR_W      = 8,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter logic [31:0]    VERSION_ID  = 32'h0101_157C,
   localparam int unsigned   DATA_W      = 2 * HALF_W,
   localparam int unsigned   PIN_COUNT   = DATA_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [PIN_COUNT-1:0] pad_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe
);

   // elaboration-time parameter checks
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_mask_port: ADDR_W too small for the register windows");
   end
   if (HALF_W < 1) begin : g_bad_half
      $error("gpio_mask_port: HALF_W must be positive");
   end

   region_e region;
   logic [NUM_CTRL-1:0][NUM_HALF-1:0][HALF_W-1:0] store;
   logic [PIN_COUNT-1:0] pad_sync;
   logic [DATA_W-1:0]    rd_next;

   gpio_mask_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr   (bus_addr),
      .region (region)
   );

   for (genvar r = 0; r < NUM_CTRL; r++) begin : g_ctrl
      for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
         logic wr_hit;
         assign wr_hit = bus_valid && bus_write && (region == half_region(r, h));
         gpio_mask_half_reg #(.HALF_W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hit),
            .wdata (bus_wdata),
            .q     (store[r][h])
         );
      end
   end

   assign pad_out = store[0];
   assign pad_oe  = store[1];

   gpio_mask_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   always_comb begin
      rd_next = '0;
      if (bus_valid && !bus_write) begin
         case (region)
            RGN_DOUT_LO: rd_next[HALF_W-1:0] = store[0][0];
            RGN_DOUT_HI: rd_next[HALF_W-1:0] = store[0][1];
            RGN_DIR_LO:  rd_next[HALF_W-1:0] = store[1][0];
            RGN_DIR_HI:  rd_next[HALF_W-1:0] = store[1][1];
            RGN_EXT:     rd_next             = pad_sync;
            RGN_VER:     rd_next             = DATA_W'(VERSION_ID);
            default:     rd_next             = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
   parameter int unsigned    HALF_W     = 16,
   parameter int unsigned    ADDR_W     = 8,
   parameter logic [31:0]    VERSION_ID = 32'h0101_157C,
   localparam int unsigned   DATA_W     = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] pad_in,
   input logic [DATA_W-1:0] pad_out,
   input logic [DATA_W-1:0] pad_oe
);

   localparam logic [ADDR_W-1:0] A_DOUT_LO = ADDR_W'('h00);
   localparam logic [ADDR_W-1:0] A_DOUT_HI = ADDR_W'('h04);
   localparam logic [ADDR_W-1:0] A_EXT     = ADDR_W'('h70);
   localparam logic [ADDR_W-1:0] A_VER     = ADDR_W'('h78);

   // edges since reset release, saturating, for history-deep checks
   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   logic half_read;
   assign half_read = bus_valid && !bus_write && (bus_addr[ADDR_W-1:4] == '0)
                      && (bus_addr[1:0] == 2'b00);

   logic known_rgn;
   assign known_rgn = (bus_addr == A_DOUT_LO) || (bus_addr == A_DOUT_HI) ||
                      (bus_addr == ADDR_W'('h08)) || (bus_addr == ADDR_W'('h0C)) ||
                      (bus_addr == A_EXT) || (bus_addr == A_VER);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0 && bus_rdata == '0));

   assert_masked_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == A_DOUT_LO) |=>
      pad_out[HALF_W-1:0] ==
         (($past(pad_out[HALF_W-1:0]) & ~$past(bus_wdata[DATA_W-1:HALF_W])) |
          ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[DATA_W-1:HALF_W]))));

   assert_other_half_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == A_DOUT_HI) |=>
      $stable(pad_out[HALF_W-1:0]));

   assert_half_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      half_read |=> bus_rdata[DATA_W-1:HALF_W] == '0);

   assert_ext_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == A_EXT && since_rst >= 3'd4) |=>
      bus_rdata == $past(pad_in, 3));

   assert_version_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == A_VER) |=> bus_rdata == DATA_W'(VERSION_ID));

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !known_rgn) |=> (bus_rdata == '0 && $stable(pad_out) && $stable(pad_oe)));

   assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
   .HALF_W     (HALF_W),
   .ADDR_W     (ADDR_W),
   .VERSION_ID (VERSION_ID)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_mask_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h00, 32'hFFFF_A5A5, 32'h0,          8'd2}, // R2 all enabled
      '{1'b0, 8'h00, 32'h0,         32'h0000_A5A5,  8'd2},
      '{1'b1, 8'h00, 32'h00F0_0000, 32'h0,          8'd2}, // clear bits 7..4 only
      '{1'b0, 8'h00, 32'h0,         32'h0000_A505,  8'd2},
      '{1'b1, 8'h04, 32'h0001_0001, 32'h0,          8'd3}, // R3 upper half
      '{1'b0, 8'h04, 32'h0,         32'h0000_0001,  8'd3},
      '{1'b0, 8'h00, 32'h0,         32'h0000_A505,  8'd3},
      '{1'b1, 8'h08, 32'hFFFF_00FF, 32'h0,          8'd4}, // R4 direction
      '{1'b1, 8'h0C, 32'h8000_8000, 32'h0,          8'd4},
      '{1'b0, 8'h08, 32'h0,         32'h0000_00FF,  8'd6}, // R6 upper zero
      '{1'b0, 8'h0C, 32'h0,         32'h0000_8000,  8'd6},
      '{1'b1, 8'h78, 32'hFFFF_FFFF, 32'h0,          8'd8}, // R8 read-only
      '{1'b0, 8'h78, 32'h0,         32'h0101_157C,  8'd8},
      '{1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0,          8'd9}, // R9 unmapped
      '{1'b0, 8'h40, 32'h0,         32'h0000_0000,  8'd9},
      '{1'b0, 8'h00, 32'h0,         32'h0000_A505,  8'd9},
      '{1'b1, 8'h00, 32'h0000_FFFF, 32'h0,          8'd2}, // no enables
      '{1'b0, 8'h00, 32'h0,         32'h0000_A505,  8'd2},
      '{1'b0, 8'h02, 32'h0,         32'h0000_0000,  8'd9}  // unaligned
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   // tasks start on a falling edge and return on a falling edge
   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = '0;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1: held in reset
      check("R1 pad_out in reset", pad_out, 32'h0);
      check("R1 pad_oe in reset", pad_oe, 32'h0);
      check("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pad_oe after release", pad_oe, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) do_write(VEC[i].addr, VEC[i].data);
         else begin
            do_read(VEC[i].addr, rd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
         end
      end

      // R5 and R4: register contents on the pads
      check("R5 pad_out", pad_out, 32'h0001_A505);
      check("R4 pad_oe", pad_oe, 32'h8000_00FF);

      // R10: write with valid low
      bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFFFF_0000;
      @(negedge clk);
      bus_write = 1'b0;
      check("R10 pad_out unchanged", pad_out, 32'h0001_A505);

      // R7: settled pad level
      pad_in = 32'hDEAD_BEEF;
      repeat (4) @(negedge clk);
      do_read(8'h70, rd);
      check("R7 settled ext port", rd, 32'hDEAD_BEEF);

      // R7: exact synchronizer latency
      pad_in = 32'h1234_5678;
      do_read(8'h70, rd);
      check("R7 first read old", rd, 32'hDEAD_BEEF);
      do_read(8'h70, rd);
      check("R7 second read old", rd, 32'hDEAD_BEEF);
      do_read(8'h70, rd);
      check("R7 third read new", rd, 32'h1234_5678);

      // R8: write to ext port ignored
      do_write(8'h70, 32'hFFFF_FFFF);
      check("R8 ext write no effect", pad_out, 32'h0001_A505);

      // R1: reset in the middle of operation
      rst_n = 1'b0;
      #1;
      check("R1 mid-run pad_out", pad_out, 32'h0);
      check("R1 mid-run pad_oe", pad_oe, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(8'h04, rd);
      check("R1 upper half after reset", rd, 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule